// File: doc/BRIEF.md
# Quadword Logic and Lane-Copy Execution Unit

This unit executes one class of operations for a register file of 128-bit multimedia registers. Each register is handled as two 64-bit doublewords, a lower one (bits 63:0) and an upper one (bits 127:64). Each issued operation carries the following:

- an operation code;
- the indices and contents of two source registers, called `rs` and `rt`;
- a destination index.

One clock after the unit accepts an operation, it returns the 128-bit result, the destination index and a write-enable for the register file.

The operations fall into two groups. The first group is the four bitwise functions, applied to both doublewords. The second group moves data:

- a halfword broadcast, kept inside each doubleword;
- a copy of the lower doublewords of both sources;
- a copy of the upper doublewords of both sources.

Register index 0 is hard-wired to zero. A source with index 0 reads as zero, and a result aimed at index 0 is never written.

Both edges of the unit are valid/ready streams. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is consumed on a clock edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output stage is empty or is being consumed in the same cycle. While the output stage holds a result that is not consumed, the result and its fields stay unchanged and `in_ready` is low. No operation is dropped or reordered.

Top module: `simd_lc_unit`

## Requirements
- R1: Operation codes 0, 1, 2 and 3 produce `rs AND rt`, `rs OR rt`, `rs XOR rt` and `NOT(rs OR rt)`. The function is applied to the lower doublewords and, separately, to the upper doublewords.
- R2: Code 4 takes bits [15:0] of each doubleword of `rt` and repeats them in all four halfwords of the same doubleword of the result. Bits [79:64] feed the upper doubleword and bits [15:0] feed the lower one.
- R3: Code 5 places the lower doubleword of `rs` in result bits [127:64] and the lower doubleword of `rt` in result bits [63:0].
- R4: Code 6 places the upper doubleword of `rs` in result bits [63:0] and the upper doubleword of `rt` in result bits [127:64].
- R5: A source whose index is 0 is read as all zeros, whatever is on its data port.
- R6: A result whose destination index is 0 is delivered with `out_wen` low.
- R7: Code 7 is reserved. Its result is delivered with `out_wen` low.
- R8: An accepted operation shows up at the output exactly one clock later when the output is not stalled. Results leave in the order they were accepted, and `out_rd_idx` carries the destination index of the operation.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data`, `out_rd_idx` and `out_wen` hold their values.
- R10: Synchronous active-high reset clears `out_valid` and `out_wen` at the next clock edge, and any result still held is discarded.
- R11: `out_wen` is never high while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can accept an operation this cycle |
| in_op | input | 3 | Operation code (0 AND, 1 OR, 2 XOR, 3 NOR, 4 broadcast, 5 copy-lower, 6 copy-upper, 7 reserved) |
| in_rs_idx | input | IDX_W (5) | Index of source rs |
| in_rt_idx | input | IDX_W (5) | Index of source rt |
| in_rd_idx | input | IDX_W (5) | Destination index |
| in_rs_data | input | 2*HALF_W (128) | Contents of rs |
| in_rt_data | input | 2*HALF_W (128) | Contents of rt |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_wen | output | 1 | The result must be written to the register file |
| out_rd_idx | output | IDX_W (5) | Destination index of the result |
| out_data | output | 2*HALF_W (128) | Result quadword |

## Verification
The bench builds the unit with its default parameters: 64-bit doublewords, 16-bit halfword slots and 5-bit indices. These values keep the real bit boundaries at 15/16 and 63/64, so the tests can detect a broadcast that leaks across doublewords and a copy whose halves are swapped. The bench draws indices from the range 0 to 3, so the zero-index cases for both sources and for the destination come up often. It drives `out_ready` at random, so back-pressure occurs together with every operation code.

// File: rtl/simd_lc_pkg.sv
package simd_lc_pkg;

  // Operation codes of the unit (3-bit field).
  typedef enum logic [2:0] {
    OP_AND   = 3'd0,
    OP_OR    = 3'd1,
    OP_XOR   = 3'd2,
    OP_NOR   = 3'd3,
    OP_BCAST = 3'd4,
    OP_CPYLO = 3'd5,
    OP_CPYHI = 3'd6,
    OP_RSVD  = 3'd7
  } op_e;

  localparam int OP_W = 3;

  // True for codes that the per-doubleword lanes compute.
  function automatic logic is_lane_op(input logic [OP_W-1:0] op);
    return (op <= OP_BCAST);
  endfunction

  // True for the two doubleword-routing codes.
  function automatic logic is_route_op(input logic [OP_W-1:0] op);
    return (op == OP_CPYLO) || (op == OP_CPYHI);
  endfunction

endpackage

// File: rtl/simd_lc_srcsel.sv
// Forces the read value of register index 0 to zero.
module simd_lc_srcsel #(
  parameter int DATA_W = 128,
  parameter int IDX_W  = 5
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);

  localparam logic [IDX_W-1:0] ZERO_IDX = '0;

  always_comb begin
    if (idx_i == ZERO_IDX) data_o = '0;
    else                   data_o = data_i;
  end

endmodule

// File: rtl/simd_lc_half.sv
// One doubleword lane: bitwise functions and halfword broadcast.
module simd_lc_half
  import simd_lc_pkg::*;
#(
  parameter int HALF_W = 64,
  parameter int SLOT_W = 16
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [HALF_W-1:0] a_i,
  input  logic [HALF_W-1:0] b_i,
  output logic [HALF_W-1:0] res_o
);

  localparam int NSLOT = HALF_W / SLOT_W;

  logic [HALF_W-1:0] bcast;

  // Repeat the least significant slot of b into every slot of the lane.
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign bcast[s*SLOT_W +: SLOT_W] = b_i[SLOT_W-1:0];
  end

  always_comb begin
    case (op_e'(op_i))
      OP_AND:   res_o = a_i & b_i;
      OP_OR:    res_o = a_i | b_i;
      OP_XOR:   res_o = a_i ^ b_i;
      OP_NOR:   res_o = ~(a_i | b_i);
      OP_BCAST: res_o = bcast;
      default:  res_o = '0;
    endcase
  end

endmodule

// File: rtl/simd_lc_route.sv
// Doubleword routing for the two copy operations.
module simd_lc_route #(
  parameter int HALF_W = 64
) (
  input  logic [2*HALF_W-1:0] rs_i,
  input  logic [2*HALF_W-1:0] rt_i,
  input  logic                upper_i,
  output logic [2*HALF_W-1:0] res_o
);

  localparam int LO = 0;
  localparam int HI = HALF_W;

  logic [HALF_W-1:0] res_lo, res_hi;

  always_comb begin
    if (upper_i) begin
      res_lo = rs_i[HI +: HALF_W];
      res_hi = rt_i[HI +: HALF_W];
    end else begin
      res_lo = rt_i[LO +: HALF_W];
      res_hi = rs_i[LO +: HALF_W];
    end
  end

  assign res_o = {res_hi, res_lo};

endmodule

// File: rtl/simd_lc_unit.sv
module simd_lc_unit
  import simd_lc_pkg::*;
#(
  parameter int HALF_W = 64,
  parameter int SLOT_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [2:0]          in_op,
  input  logic [IDX_W-1:0]    in_rs_idx,
  input  logic [IDX_W-1:0]    in_rt_idx,
  input  logic [IDX_W-1:0]    in_rd_idx,
  input  logic [2*HALF_W-1:0] in_rs_data,
  input  logic [2*HALF_W-1:0] in_rt_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_wen,
  output logic [IDX_W-1:0]    out_rd_idx,
  output logic [2*HALF_W-1:0] out_data
);

  localparam int QW    = 2 * HALF_W;
  localparam int NHALF = 2;

  logic [QW-1:0] rs_z, rt_z;
  logic [QW-1:0] lane_res, route_res;
  logic [QW-1:0] res_next;
  logic          wen_next;
  logic          accept;

  simd_lc_srcsel #(.DATA_W(QW), .IDX_W(IDX_W)) u_rs_sel (
    .idx_i (in_rs_idx),
    .data_i(in_rs_data),
    .data_o(rs_z)
  );

  simd_lc_srcsel #(.DATA_W(QW), .IDX_W(IDX_W)) u_rt_sel (
    .idx_i (in_rt_idx),
    .data_i(in_rt_data),
    .data_o(rt_z)
  );

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    simd_lc_half #(.HALF_W(HALF_W), .SLOT_W(SLOT_W)) u_half (
      .op_i (in_op),
      .a_i  (rs_z[h*HALF_W +: HALF_W]),
      .b_i  (rt_z[h*HALF_W +: HALF_W]),
      .res_o(lane_res[h*HALF_W +: HALF_W])
    );
  end

  simd_lc_route #(.HALF_W(HALF_W)) u_route (
    .rs_i   (rs_z),
    .rt_i   (rt_z),
    .upper_i(in_op == OP_CPYHI),
    .res_o  (route_res)
  );

  always_comb begin
    if (is_route_op(in_op))     res_next = route_res;
    else if (is_lane_op(in_op)) res_next = lane_res;
    else                        res_next = '0;
  end

  assign wen_next = (in_op != OP_RSVD) && (in_rd_idx != '0);

  // Single output register; it advances when empty or being drained.
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_wen   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      out_wen   <= in_valid && wen_next;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      out_rd_idx <= in_rd_idx;
      out_data   <= res_next;
    end
  end

endmodule

// File: rtl/simd_lc_chk.sv
module simd_lc_chk #(
  parameter int HALF_W = 64,
  parameter int IDX_W  = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic [2:0]          in_op,
  input logic [IDX_W-1:0]    in_rs_idx,
  input logic [IDX_W-1:0]    in_rt_idx,
  input logic [IDX_W-1:0]    in_rd_idx,
  input logic [2*HALF_W-1:0] in_rs_data,
  input logic [2*HALF_W-1:0] in_rt_data,
  input logic                out_valid,
  input logic                out_ready,
  input logic                out_wen,
  input logic [IDX_W-1:0]    out_rd_idx,
  input logic [2*HALF_W-1:0] out_data
);

  p_wen_needs_valid_r11: assert property (@(posedge clk) disable iff (rst)
    out_wen |-> out_valid);

  p_no_write_zero_r6: assert property (@(posedge clk) disable iff (rst)
    out_wen |-> (out_rd_idx != '0));

  p_reserved_silent_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_op == 3'd7) |=> !out_wen);

  p_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && out_rd_idx == $past(in_rd_idx)));

  p_stall_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_stall_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_rd_idx) && $stable(out_wen)));

  p_and_both_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_op == 3'd0 && in_rs_idx != '0 && in_rt_idx != '0)
      |=> (out_data == ($past(in_rs_data) & $past(in_rt_data))));

endmodule

bind simd_lc_unit simd_lc_chk #(.HALF_W(HALF_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
  .in_rs_idx(in_rs_idx), .in_rt_idx(in_rt_idx), .in_rd_idx(in_rd_idx),
  .in_rs_data(in_rs_data), .in_rt_data(in_rt_data), .out_valid(out_valid),
  .out_ready(out_ready), .out_wen(out_wen), .out_rd_idx(out_rd_idx), .out_data(out_data)
);

// File: tb/test_simd_lc_unit.sv
module test_simd_lc_unit;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [2:0]   in_op = '0;
  logic [4:0]   in_rs_idx = '0, in_rt_idx = '0, in_rd_idx = '0;
  logic [127:0] in_rs_data = '0, in_rt_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic         out_wen;
  logic [4:0]   out_rd_idx;
  logic [127:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_lc_unit i_simd_lc_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_rs_idx(in_rs_idx), .in_rt_idx(in_rt_idx), .in_rd_idx(in_rd_idx),
    .in_rs_data(in_rs_data), .in_rt_data(in_rt_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_wen(out_wen), .out_rd_idx(out_rd_idx), .out_data(out_data)
  );

  typedef struct {
    bit         wen;
    bit [4:0]   rd;
    bit [127:0] data;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   stalled_prev = 0;
  bit   done = 0;

  function automatic bit [127:0] ref_calc(int op, bit [127:0] a, bit [127:0] b);
    bit [127:0] r = '0;
    case (op)
      0: r = a & b;
      1: r = a | b;
      2: r = a ^ b;
      3: r = ~(a | b);
      4: for (int h = 0; h < 2; h++)
           for (int k = 0; k < 4; k++)
             r[h*64 + k*16 +: 16] = b[h*64 +: 16];
      5: r = {a[63:0], b[63:0]};
      6: r = {b[127:64], a[127:64]};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string op_tag(int op, int rsi, int rti, int rdi);
    string t;
    case (op)
      0, 1, 2, 3: t = "R1";
      4: t = "R2";
      5: t = "R3";
      6: t = "R4";
      default: t = "R7";
    endcase
    if (rdi == 0) t = {t, "/R6"};
    if (rsi == 0 || rti == 0) t = {t, "/R5"};
    return t;
  endfunction

  task automatic fail_line(string tag, string what, logic [127:0] got, logic [127:0] exp);
    errors++;
    $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
  endtask

  // Compare outputs against the model; called away from the clock edge.
  task automatic check_outputs();
    checks++;
    if (out_valid !== (q.size() != 0))
      fail_line("R8", "out_valid", 128'(out_valid), 128'(q.size() != 0));
    if (!out_valid && out_wen === 1'b1) begin
      checks++;
      fail_line("R11", "out_wen without valid", 128'(out_wen), 128'(0));
    end
    if (out_valid && q.size() != 0) begin
      exp_t e = q[0];
      string t = stalled_prev ? {e.tag, "/R9"} : e.tag;
      checks++;
      if (out_wen !== e.wen)
        fail_line(t, "out_wen", 128'(out_wen), 128'(e.wen));
      else if (e.wen && out_rd_idx !== e.rd)
        fail_line({t, "/R8"}, "out_rd_idx", 128'(out_rd_idx), 128'(e.rd));
      else if (e.wen && out_data !== e.data)
        fail_line(t, "out_data", out_data, e.data);
    end
  endtask

  task automatic cycle(bit v, int op, int rsi, int rti, int rdi,
                       bit [127:0] a, bit [127:0] b, bit rdy);
    @(negedge clk);
    check_outputs();
    in_valid   = v;
    in_op      = op[2:0];
    in_rs_idx  = rsi[4:0];
    in_rt_idx  = rti[4:0];
    in_rd_idx  = rdi[4:0];
    in_rs_data = a;
    in_rt_data = b;
    out_ready  = rdy;
    #1;
    checks++;
    if (out_valid && !out_ready && in_ready !== 1'b0)
      fail_line("R9", "in_ready during stall", 128'(in_ready), 128'(0));
    if (out_valid && out_ready) void'(q.pop_front());
    if (in_valid && in_ready) begin
      exp_t e;
      bit [127:0] az = (rsi == 0) ? '0 : a;
      bit [127:0] bz = (rti == 0) ? '0 : b;
      e.wen  = (op != 7) && (rdi != 0);
      e.rd   = rdi[4:0];
      e.data = ref_calc(op, az, bz);
      e.tag  = op_tag(op, rsi, rti, rdi);
      q.push_back(e);
    end
    stalled_prev = out_valid && !out_ready;
  endtask

  function automatic bit [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    bit [127:0] pa = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
    bit [127:0] pb = 128'hf0f0_0ff0_aaaa_5555_1234_5678_9abc_beef;
    // R10: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_wen !== 1'b0)
      fail_line("R10", "reset outputs", {out_valid, out_wen}, 128'(0));
    rst = 1'b0;

    // R1..R4, R7: each code with non-zero indices
    for (int op = 0; op < 8; op++) cycle(1, op, 1, 2, 3, pa, pb, 1);
    // R2: broadcast with distinct slot values in each half
    cycle(1, 4, 1, 2, 7, pa, 128'h1111_2222_3333_abcd_5555_6666_7777_8001, 1);
    // R5: zero source indices
    cycle(1, 1, 0, 2, 4, pa, pb, 1);
    cycle(1, 1, 1, 0, 4, pa, pb, 1);
    cycle(1, 5, 0, 2, 4, pa, pb, 1);
    cycle(1, 6, 1, 0, 4, pa, pb, 1);
    // R6: destination zero
    cycle(1, 2, 1, 2, 0, pa, pb, 1);
    // R9: stall with an offered operation
    cycle(1, 3, 1, 2, 5, pa, pb, 0);
    cycle(1, 0, 2, 1, 6, pb, pa, 0);
    cycle(1, 0, 2, 1, 6, pb, pa, 0);
    cycle(1, 0, 2, 1, 6, pb, pa, 1);
    cycle(0, 0, 0, 0, 0, '0, '0, 1);
    cycle(0, 0, 0, 0, 0, '0, '0, 1);

    // Random traffic with random back-pressure
    for (int n = 0; n < 3000; n++)
      cycle($urandom_range(0, 3) != 0, $urandom_range(0, 7), $urandom_range(0, 3),
            $urandom_range(0, 3), $urandom_range(0, 3), rnd128(), rnd128(),
            $urandom_range(0, 2) != 0);

    // R10: reset with a held result
    cycle(1, 1, 1, 2, 3, pa, pb, 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_wen !== 1'b0)
      fail_line("R10", "reset discards held result", {out_valid, out_wen}, 128'(0));
    q.delete();
    rst = 1'b0;
    in_valid = 1'b0;
    stalled_prev = 0;
    cycle(0, 0, 0, 0, 0, '0, '0, 1);
    cycle(0, 0, 0, 0, 0, '0, '0, 1);
    finish_run();
  end

endmodule